// File: doc/BRIEF.md
# IR Transmit Run-Length Modulator

This block turns a stream of run-length coded bytes into an infrared emitter drive signal. The host pushes bytes into a 16-entry transmit FIFO. The modulator takes them one at a time and plays each one as a timed run. A pulse run gates a carrier derived from the system clock onto the output. A space run holds the output at its inactive level. Run durations are counted in ticks of an external 10 µs strobe. Consecutive bytes play back to back with no gap.

The carrier frequency is chosen with a 5-bit code. A 2-bit select steers the modulated signal to one of four emitter pins, and an invert bit flips the polarity of all four pins. The host raises an end-of-transmission flag before it writes the final byte of a message, so running dry after that byte ends the message cleanly. Running dry without the flag sets a sticky underrun flag. Two level flags tell the host when the FIFO is nearly empty and when it is empty.

Top module: `irtx_runlen_mod`

## Requirements
- R1: Byte format: bit 7 is 1 for a space run and 0 for a pulse run. Bits 6:0 hold X, and the run lasts X+1 cycles of `tick_10us` counted while the run plays. During a space run the output stays at its inactive level.
- R2: When a run ends and another byte is waiting, the next byte starts on the same clock edge, and `emit_out` shows the new run one clock later.
- R3: A byte written into an idle, empty modulator starts on the clock edge after the write edge, and `emit_out` shows it one edge after that. The carrier phase restarts at the start of every pulse run, so a pulse begins with the carrier in its high part.
- R4: Carrier frequency by code: codes 0, 1 and 2 give 58, 59 and 60 kHz. Codes 3 to 29 give (code+27) kHz. Code 30 gives 56.9 kHz. Code 31 falls back to 36 kHz. The carrier period in clocks is CLK_HZ/f rounded to nearest.
- R5: Each carrier period is high for 7 µs (350 clocks at 50 MHz) and low for the rest. The 36 kHz default is reached with code 9.
- R6: The FIFO holds 16 bytes, not counting the byte being played. A write while 16 bytes are held is discarded.
- R7: `irq_low` is 1 while 3 or fewer bytes wait in the FIFO. `irq_empty` is 1 while none wait.
- R8: A one-cycle `eot_set` arms an end flag. When a run ends with the FIFO empty and the flag armed, the output goes idle, the flag clears, and `underrun` stays 0.
- R9: When a run ends with the FIFO empty and no end flag armed, `underrun` becomes 1 on that edge. It holds until `underrun_clr` is 1 for a cycle. A new underrun in the same cycle as a clear wins.
- R10: `emit_sel` picks the single pin of `emit_out` that carries the modulated signal. The other three pins stay at the inactive level.
- R11: When `invert` is 1, all four pins are inverted, so the inactive level becomes 1.
- R12: While no run plays, every pin sits at the inactive level. Ticks that arrive while the modulator is idle have no effect on the next run.
- R13: After reset, `emit_out` is 0, `underrun` is 0, and `irq_low` and `irq_empty` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 8 | Run-length byte (bit 7 space flag, bits 6:0 length) |
| eot_set | input | 1 | Arm the end-of-transmission flag |
| tick_10us | input | 1 | One-cycle duration strobe |
| carrier_code | input | 5 | Carrier frequency code |
| emit_sel | input | 2 | Emitter pin select |
| invert | input | 1 | Output polarity invert |
| underrun_clr | input | 1 | Write-one clear of `underrun` |
| irq_low | output | 1 | FIFO holds 3 or fewer bytes |
| irq_empty | output | 1 | FIFO holds no bytes |
| underrun | output | 1 | Sticky underrun flag |
| emit_out | output | 4 | Emitter drive pins |

## Verification
Each result has a fixed arrival time. A written byte is popped one edge after the write and shows on `emit_out` one edge after the pop. A run ends on the edge that carries its (X+1)th tick, and the next run shows one edge later. `underrun` and the FIFO flags change on the edge of the tick or the write that causes them. The bench drives inputs and samples outputs on falling edges and counts the exact number of edges before each sample. For the carrier sweep it times the high and low phases of one full period for every code and compares them against periods computed arithmetically from the code.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned LEN_W   = 7;
   localparam int unsigned CODE_W  = 5;
   localparam int unsigned N_CODES = 2 ** CODE_W;

   typedef struct packed {
      logic             space;
      logic [LEN_W-1:0] len;
   } run_byte_t;

   // carrier frequency in Hz selected by a code
   function automatic int unsigned carrier_hz(input int unsigned code);
      if (code <= 2)        return 58000 + 1000 * code;
      else if (code == 30)  return 56900;
      else if (code >= 31)  return 36000;
      else                  return (code + 27) * 1000;
   endfunction

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 8,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic [CW-1:0]    count
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("irtx_fifo: DEPTH must be a power of two");
   end

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             wr_ok;

   assign wr_ok   = wr_en && (count != FULL_CNT);
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && count == FULL_CNT && !rd_en) |=> count == FULL_CNT); // R6

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
   import irtx_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 50_000_000,
   parameter int unsigned HIGH_US = 7,
   localparam int unsigned PER_W    = $clog2(CLK_HZ / 25000),
   localparam int unsigned HIGH_CYC = (CLK_HZ / 1_000_000) * HIGH_US
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] code,
   output logic              carrier_hi
);

   if (HIGH_CYC == 0 || HIGH_CYC >= CLK_HZ / 60000) begin : g_bad_high
      $error("irtx_carrier: high time must fit inside the shortest carrier period");
   end

   localparam logic [PER_W-1:0] HIGH_P = PER_W'(HIGH_CYC);

   logic [PER_W-1:0] period_tab [N_CODES];
   logic [PER_W-1:0] period;
   logic [PER_W-1:0] phase;

   for (genvar g = 0; g < N_CODES; g++) begin : g_tab
      assign period_tab[g] =
         PER_W'((CLK_HZ + carrier_hz(g) / 2) / carrier_hz(g));
   end

   assign period     = period_tab[code];
   assign carrier_hi = (phase < HIGH_P);

   always_ff @(posedge clk) begin
      if (!rst_n)                      phase <= '0;
      else if (restart)                phase <= '0;
      else if (phase >= period - 1'b1) phase <= '0;
      else                             phase <= phase + 1'b1;
   end

   AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == '0 && carrier_hi)); // R3

endmodule

// File: rtl/irtx_player.sv
module irtx_player
   import irtx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      eot_set,
   input  logic      underrun_clr,
   input  logic      fifo_empty,
   input  run_byte_t fifo_byte,
   output logic      fifo_pop,
   output logic      playing,
   output logic      in_space,
   output logic      underrun
);

   logic [LEN_W:0] remain;
   logic           eot_q;
   logic           last_tick;
   logic           dry;

   assign last_tick = playing && tick && (remain == 1);
   assign fifo_pop  = (!playing || last_tick) && !fifo_empty;
   assign dry       = last_tick && fifo_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         playing  <= 1'b0;
         in_space <= 1'b0;
         remain   <= '0;
      end else if (fifo_pop) begin
         playing  <= 1'b1;
         in_space <= fifo_byte.space;
         remain   <= {1'b0, fifo_byte.len} + 1'b1;
      end else if (dry) begin
         playing  <= 1'b0;
      end else if (playing && tick) begin
         remain   <= remain - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eot_q    <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (eot_set)  eot_q <= 1'b1;
         else if (dry) eot_q <= 1'b0;
         if (dry && !eot_q)     underrun <= 1'b1;
         else if (underrun_clr) underrun <= 1'b0;
      end
   end

   AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty); // R6
   AST_UNDERRUN_NEEDS_NO_EOT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> !$past(eot_q)); // R9
   AST_IDLE_IGNORES_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!playing && fifo_empty) |=> !playing); // R12
   AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (playing && !tick) |=> (playing && $stable(remain))); // R1

endmodule

// File: rtl/irtx_runlen_mod.sv
module irtx_runlen_mod
   import irtx_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 50_000_000,
   parameter int unsigned HIGH_US   = 7,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned LOW_MARK  = 3,
   parameter int unsigned NUM_EMIT  = 4,
   localparam int unsigned SEL_W    = $clog2(NUM_EMIT),
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [BYTE_W-1:0]   wr_data,
   input  logic                eot_set,
   input  logic                tick_10us,
   input  logic [CODE_W-1:0]   carrier_code,
   input  logic [SEL_W-1:0]    emit_sel,
   input  logic                invert,
   input  logic                underrun_clr,
   output logic                irq_low,
   output logic                irq_empty,
   output logic                underrun,
   output logic [NUM_EMIT-1:0] emit_out
);

   if (LOW_MARK >= DEPTH) begin : g_bad_mark
      $error("irtx_runlen_mod: LOW_MARK must be below DEPTH");
   end

   localparam logic [CW-1:0] LOW_CNT = CW'(LOW_MARK);

   logic [BYTE_W-1:0]   fifo_q;
   logic [CW-1:0]       level;
   logic                fifo_pop;
   logic                playing;
   logic                in_space;
   logic                carrier_hi;
   logic                sig;
   logic [NUM_EMIT-1:0] emit_d;

   irtx_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (fifo_pop),
      .rd_data (fifo_q),
      .count   (level)
   );

   irtx_player u_player (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick_10us),
      .eot_set      (eot_set),
      .underrun_clr (underrun_clr),
      .fifo_empty   (level == '0),
      .fifo_byte    (run_byte_t'(fifo_q)),
      .fifo_pop     (fifo_pop),
      .playing      (playing),
      .in_space     (in_space),
      .underrun     (underrun)
   );

   irtx_carrier #(.CLK_HZ(CLK_HZ), .HIGH_US(HIGH_US)) u_carrier (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (fifo_pop),
      .code       (carrier_code),
      .carrier_hi (carrier_hi)
   );

   assign irq_low   = (level <= LOW_CNT);
   assign irq_empty = (level == '0);
   assign sig       = playing && !in_space && carrier_hi;

   for (genvar i = 0; i < NUM_EMIT; i++) begin : g_pin
      assign emit_d[i] = ((emit_sel == SEL_W'(i)) && sig) ^ invert;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) emit_out <= '0;
      else        emit_out <= emit_d;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !playing |=> (emit_out == {NUM_EMIT{$past(invert)}})); // R12
   AST_ONE_PIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(emit_out) || $onehot0(~emit_out)); // R10
   AST_SPACE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (playing && in_space) |=> (emit_out == {NUM_EMIT{$past(invert)}})); // R1

endmodule

// File: tb/irtx_runlen_mod_test.sv
`timescale 1ns/1ps
module irtx_runlen_mod_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       eot_set = 1'b0;
   logic       tick_10us = 1'b0;
   logic [4:0] carrier_code = 5'd9;
   logic [1:0] emit_sel = '0;
   logic       invert = 1'b0;
   logic       underrun_clr = 1'b0;
   logic       irq_low, irq_empty, underrun;
   logic [3:0] emit_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #10 clk = ~clk;

   irtx_runlen_mod uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .eot_set(eot_set), .tick_10us(tick_10us), .carrier_code(carrier_code),
      .emit_sel(emit_sel), .invert(invert), .underrun_clr(underrun_clr),
      .irq_low(irq_low), .irq_empty(irq_empty), .underrun(underrun),
      .emit_out(emit_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic nedge();
      @(negedge clk);
   endtask

   task automatic push(input bit space, input int len);
      wr_en = 1'b1; wr_data = {space, 7'(len)};
      nedge();
      wr_en = 1'b0;
   endtask

   task automatic tick();
      tick_10us = 1'b1;
      nedge();
      tick_10us = 1'b0;
   endtask

   task automatic arm_eot();
      eot_set = 1'b1;
      nedge();
      eot_set = 1'b0;
   endtask

   function automatic int exp_period(input int code);
      int hz;
      if (code <= 2)       hz = 58000 + 1000 * code;
      else if (code == 30) hz = 56900;
      else if (code == 31) hz = 36000;
      else                 hz = (code + 27) * 1000;
      return (50_000_000 + hz / 2) / hz;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int hi, lo;
      repeat (3) nedge();
      rst_n = 1'b1;
      nedge();
      // R13 reset state
      chk("R13 emit", emit_out, 0);
      chk("R13 underrun", underrun, 0);
      chk("R13 irq_low", irq_low, 1);
      chk("R13 irq_empty", irq_empty, 1);

      // R3 start latency, pulse begins high
      arm_eot();
      push(0, 0);
      chk("R3 before pop", emit_out, 0);
      nedge();
      chk("R3 pop edge", emit_out, 0);
      nedge();
      chk("R3 first output", emit_out, 1);
      tick(); nedge();
      chk("R8 idle after eot", emit_out, 0);
      chk("R8 no underrun", underrun, 0);

      // R1 R2 space length sweep followed by pulse
      for (int x = 0; x < 128; x++) begin
         arm_eot();
         push(1, x);
         push(0, 0);
         for (int t = 0; t < x; t++) tick();
         nedge();
         chk("R1 space still idle", emit_out, 0);
         tick(); nedge();
         chk("R2 pulse follows space", emit_out, 1);
         tick(); nedge();
         chk("R8 clean end", {underrun, emit_out}, 0);
      end

      // R12 idle ticks ignored
      repeat (5) tick();
      arm_eot();
      push(0, 1);
      nedge(); nedge();
      tick(); nedge();
      chk("R12 run not shortened", emit_out, 1);
      tick(); nedge();
      chk("R12 run ends on second tick", emit_out, 0);

      // R9 underrun
      push(0, 2);
      nedge();
      tick(); tick();
      chk("R9 no underrun yet", underrun, 0);
      tick();
      chk("R9 underrun set", underrun, 1);
      nedge();
      chk("R9 idle after underrun", emit_out, 0);
      chk("R9 underrun sticky", underrun, 1);
      underrun_clr = 1'b1; nedge(); underrun_clr = 1'b0;
      chk("R9 underrun cleared", underrun, 0);

      // R10 R11 select and invert
      for (int inv = 0; inv < 2; inv++) begin
         for (int s = 0; s < 4; s++) begin
            invert = 1'(inv); emit_sel = 2'(s);
            nedge(); nedge();
            chk("R11 idle level", emit_out, inv ? 15 : 0);
            arm_eot();
            push(0, 0);
            nedge(); nedge();
            chk("R10 selected pin", emit_out, (1 << s) ^ (inv ? 15 : 0));
            tick(); nedge();
            chk("R12 idle after run", emit_out, inv ? 15 : 0);
         end
      end
      invert = 1'b0; emit_sel = 2'd0;
      nedge();

      // R6 R7 depth and flags
      arm_eot();
      push(0, 0);
      nedge();
      chk("R7 empty while playing", {irq_low, irq_empty}, 3);
      for (int n = 1; n <= 16; n++) begin
         push(1, 0);
         chk("R7 low on fill", irq_low, (n <= 3) ? 1 : 0);
         chk("R7 empty on fill", irq_empty, 0);
      end
      push(1, 0); push(1, 0);
      for (int j = 1; j <= 16; j++) begin
         tick();
         chk("R6 low on drain", irq_low, (16 - j <= 3) ? 1 : 0);
         chk("R6 empty on drain", irq_empty, (j == 16) ? 1 : 0);
      end
      tick(); nedge();
      chk("R6 drops extra writes", underrun, 0);
      chk("R6 idle after drain", emit_out, 0);

      // R4 R5 carrier sweep
      for (int c = 0; c < 32; c++) begin
         carrier_code = 5'(c);
         arm_eot();
         push(0, 0);
         for (int w = 0; w < 8 && emit_out[0] == 1'b0; w++) nedge();
         hi = 0; lo = 0;
         while (emit_out[0] == 1'b1 && hi < 4000) begin hi++; nedge(); end
         while (emit_out[0] == 1'b0 && lo < 4000) begin lo++; nedge(); end
         chk($sformatf("R4 period code %0d", c), hi + lo, exp_period(c));
         chk($sformatf("R5 high time code %0d", c), hi, 350);
         tick(); nedge();
      end
      carrier_code = 5'd9;

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule